// File: doc/BRIEF.md
# DS3 Framing Overhead Insertion Port

This block sits in the transmit path of a DS3 framer, in the line clock domain. It takes the framer's serial M-frame bit stream, one bit for each cycle in which the bit strobe is high, and tracks where each bit falls in the 4760-bit M-frame. Each M-frame holds 56 blocks of 85 bits. The first bit of every block is a framing overhead bit (X, P, M, F or C). All other bits are payload.

External logic can overwrite any overhead bit through a slow, bit-serial port. The block generates a port clock that completes one period per 85-bit block. On the falling edge of that clock, the block moves the start-of-sequence output and samples the data and enable inputs. External logic reads the start-of-sequence output and presents new data and enable on the rising edge.

A sampled enable replaces the matching overhead bit with the sampled data. When the enable is clear, the framer's own bit is kept. Each of the four port signals has its own polarity inversion. Port inputs pass through a two-flop synchronizer before use.

Top module: `ds3oh_insert`

## Requirements
- R1: Synchronous active-high reset puts the next accepted bit at block 0, position 0 (the first X-bit). During reset, the non-inverted port clock is high, the non-inverted start output is low, `tx_vld` is low, and no overwrite is staged.
- R2: Only accepted bits advance the frame position. An accepted bit at position 0 of an 85-bit block is an overhead slot, and 56 blocks form one 4760-bit M-frame.
- R3: Every accepted payload bit (block position 1 to 84) appears unchanged on `tx_out`, with `tx_vld` high, in the next cycle.
- R4: An overhead slot is output as the sampled external data when the sampled enable is 1. Otherwise it is output as the framer's own `tx_in` bit.
- R5: The non-inverted port clock falls one cycle after the bit at block position 42 is accepted, and rises one cycle after the bit at position 84 is accepted. This gives one period per block, with the rising edge at the start of each block.
- R6: The non-inverted start output rises at the falling edge during block 54 and falls at the falling edge during block 55. It is therefore high for exactly the port cycle that carries overhead slot 0 (the first X-bit).
- R7: Data and enable that external logic presents at the rising edge at the start of block k are sampled at the next falling edge, and they apply to overhead slot k+1 (mod 56).
- R8: Each polarity input inverts its own signal: `inv_clk` inverts `oh_clk`, `inv_sof` inverts `oh_sof`, `inv_data` inverts `oh_data`, and `inv_ena` inverts `oh_ena`. The inversion of the two inputs is applied before they are used.
- R9: A cycle with `bit_en` low accepts no bit. The next cycle has `tx_vld` low, and the frame position holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Line clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_en | input | 1 | Strobe that accepts one line bit this cycle |
| tx_in | input | 1 | Framer's bit stream, including its own overhead bits |
| tx_out | output | 1 | Bit stream after insertion |
| tx_vld | output | 1 | `tx_out` carries a bit this cycle |
| oh_clk | output | 1 | Slow overhead port clock |
| oh_sof | output | 1 | Start-of-sequence marker for the first X-bit |
| oh_data | input | 1 | External overhead bit value |
| oh_ena | input | 1 | External overwrite enable |
| inv_clk | input | 1 | Invert `oh_clk` |
| inv_sof | input | 1 | Invert `oh_sof` |
| inv_data | input | 1 | Invert `oh_data` |
| inv_ena | input | 1 | Invert `oh_ena` |

## Verification
On every cycle, the assertions check the following:
- payload bits pass through untouched;
- an overhead slot with no staged enable keeps the framer's bit;
- the port clock falls only at block position 42;
- the start marker rises only at the falling edge inside block 54;
- idle strobes produce no output and leave the position unchanged.

Only the bench scenarios can show the end-to-end timing of the port. The bench acts as the external logic. It reacts to port clock edges after decoding the polarity, places its data in the intended slot, and sees that data come out in the right frame bit. This is repeated across enable patterns, strobe gaps and mixed inversion settings.

// File: rtl/ds3oh_pkg.sv
package ds3oh_pkg;

    // Registered output stage of the insertion path
    typedef struct packed {
        logic bit_v;
        logic vld;
    } ds3oh_out_t;

    // State of the overhead port
    typedef struct packed {
        logic clk_raw;
        logic sof_raw;
        logic stg_en;
        logic stg_dat;
    } ds3oh_port_t;

endpackage

// File: rtl/ds3oh_sync.sv
module ds3oh_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [STAGES-1:0][WIDTH-1:0] pipe_d;
    logic [STAGES-1:0][WIDTH-1:0] pipe_q;

    always_comb begin
        pipe_d[0] = din;
        for (int s = 1; s < STAGES; s++) begin
            pipe_d[s] = pipe_q[s-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign dout = pipe_q[STAGES-1];

endmodule

// File: rtl/ds3oh_frame_ctr.sv
module ds3oh_frame_ctr #(
    parameter int BLOCK_BITS = 85,
    parameter int BLOCKS     = 56,
    localparam int BW        = $clog2(BLOCK_BITS),
    localparam int KW        = $clog2(BLOCKS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          step,
    output logic [BW-1:0] bpos,
    output logic [KW-1:0] blk,
    output logic          oh_slot
);

    typedef struct packed {
        logic [BW-1:0] bpos;
        logic [KW-1:0] blk;
    } ctr_t;

    ctr_t ctr_d, ctr_q;

    always_comb begin
        ctr_d = ctr_q;
        if (step) begin
            if (ctr_q.bpos == BW'(BLOCK_BITS - 1)) begin
                ctr_d.bpos = '0;
                if (ctr_q.blk == KW'(BLOCKS - 1)) begin
                    ctr_d.blk = '0;
                end else begin
                    ctr_d.blk = ctr_q.blk + 1'b1;
                end
            end else begin
                ctr_d.bpos = ctr_q.bpos + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctr_q <= '0;
        end else begin
            ctr_q <= ctr_d;
        end
    end

    assign bpos    = ctr_q.bpos;
    assign blk     = ctr_q.blk;
    assign oh_slot = (ctr_q.bpos == '0);

endmodule

// File: rtl/ds3oh_port.sv
module ds3oh_port
    import ds3oh_pkg::*;
#(
    parameter int BLOCK_BITS = 85,
    parameter int BLOCKS     = 56,
    parameter int FALL_POS   = 42,
    localparam int BW        = $clog2(BLOCK_BITS),
    localparam int KW        = $clog2(BLOCKS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          step,
    input  logic [BW-1:0] bpos,
    input  logic [KW-1:0] blk,
    input  logic          ext_dat,
    input  logic          ext_en,
    output logic          clk_raw,
    output logic          sof_raw,
    output logic          stg_en,
    output logic          stg_dat
);

    ds3oh_port_t port_d, port_q;

    always_comb begin
        port_d = port_q;
        if (step) begin
            if (bpos == BW'(FALL_POS)) begin
                // Falling edge: move the marker and stage values for the next slot
                port_d.clk_raw = 1'b0;
                port_d.sof_raw = (blk == KW'(BLOCKS - 2));
                port_d.stg_en  = ext_en;
                port_d.stg_dat = ext_dat;
            end else if (bpos == BW'(BLOCK_BITS - 1)) begin
                port_d.clk_raw = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            port_q <= '{clk_raw: 1'b1, sof_raw: 1'b0, stg_en: 1'b0, stg_dat: 1'b0};
        end else begin
            port_q <= port_d;
        end
    end

    assign clk_raw = port_q.clk_raw;
    assign sof_raw = port_q.sof_raw;
    assign stg_en  = port_q.stg_en;
    assign stg_dat = port_q.stg_dat;

endmodule

// File: rtl/ds3oh_insert.sv
module ds3oh_insert
    import ds3oh_pkg::*;
#(
    parameter int BLOCK_BITS  = 85,
    parameter int BLOCKS      = 56,
    parameter int FALL_POS    = 42,
    parameter int SYNC_STAGES = 2,
    localparam int BW         = $clog2(BLOCK_BITS),
    localparam int KW         = $clog2(BLOCKS)
) (
    input  logic clk,
    input  logic rst,
    input  logic bit_en,
    input  logic tx_in,
    output logic tx_out,
    output logic tx_vld,
    output logic oh_clk,
    output logic oh_sof,
    input  logic oh_data,
    input  logic oh_ena,
    input  logic inv_clk,
    input  logic inv_sof,
    input  logic inv_data,
    input  logic inv_ena
);

    logic [BW-1:0] bpos;
    logic [KW-1:0] blk;
    logic          oh_slot;
    logic [1:0]    pin_sync;
    logic          ext_dat;
    logic          ext_en;
    logic          clk_raw;
    logic          sof_raw;
    logic          stg_en;
    logic          stg_dat;

    ds3oh_frame_ctr #(
        .BLOCK_BITS(BLOCK_BITS),
        .BLOCKS    (BLOCKS)
    ) u_ctr (
        .clk    (clk),
        .rst    (rst),
        .step   (bit_en),
        .bpos   (bpos),
        .blk    (blk),
        .oh_slot(oh_slot)
    );

    ds3oh_sync #(
        .WIDTH (2),
        .STAGES(SYNC_STAGES)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .din ({oh_ena, oh_data}),
        .dout(pin_sync)
    );

    assign ext_en  = pin_sync[1] ^ inv_ena;
    assign ext_dat = pin_sync[0] ^ inv_data;

    ds3oh_port #(
        .BLOCK_BITS(BLOCK_BITS),
        .BLOCKS    (BLOCKS),
        .FALL_POS  (FALL_POS)
    ) u_port (
        .clk    (clk),
        .rst    (rst),
        .step   (bit_en),
        .bpos   (bpos),
        .blk    (blk),
        .ext_dat(ext_dat),
        .ext_en (ext_en),
        .clk_raw(clk_raw),
        .sof_raw(sof_raw),
        .stg_en (stg_en),
        .stg_dat(stg_dat)
    );

    ds3oh_out_t out_d, out_q;

    always_comb begin
        out_d     = out_q;
        out_d.vld = bit_en;
        if (bit_en) begin
            out_d.bit_v = (oh_slot && stg_en) ? stg_dat : tx_in;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign tx_out = out_q.bit_v;
    assign tx_vld = out_q.vld;
    assign oh_clk = clk_raw ^ inv_clk;
    assign oh_sof = sof_raw ^ inv_sof;

endmodule

// File: rtl/ds3oh_insert_chk.sv
module ds3oh_insert_chk #(
    parameter int BLOCK_BITS = 85,
    parameter int BLOCKS     = 56,
    parameter int FALL_POS   = 42,
    localparam int BW        = $clog2(BLOCK_BITS),
    localparam int KW        = $clog2(BLOCKS)
) (
    input logic          clk,
    input logic          rst,
    input logic          bit_en,
    input logic          tx_in,
    input logic          tx_out,
    input logic          tx_vld,
    input logic          oh_clk,
    input logic          oh_sof,
    input logic          inv_clk,
    input logic          inv_sof,
    input logic [BW-1:0] bpos,
    input logic [KW-1:0] blk,
    input logic          stg_en
);

    logic pclk;
    logic psof;
    assign pclk = oh_clk ^ inv_clk;
    assign psof = oh_sof ^ inv_sof;

    // R3
    payload_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (bit_en && bpos != '0) |=> (tx_vld && tx_out == $past(tx_in)));

    // R4
    keep_internal_chk: assert property (@(posedge clk) disable iff (rst)
        (bit_en && bpos == '0 && !stg_en) |=> (tx_out == $past(tx_in)));

    // R5
    clk_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(pclk) |-> ($past(bit_en) && $past(bpos) == BW'(FALL_POS)));

    // R6
    sof_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(psof) |-> ($fell(pclk) && $past(blk) == KW'(BLOCKS - 2)));

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !bit_en |=> (!tx_vld && $stable(bpos) && $stable(blk)));

endmodule

bind ds3oh_insert ds3oh_insert_chk #(
    .BLOCK_BITS(BLOCK_BITS),
    .BLOCKS    (BLOCKS),
    .FALL_POS  (FALL_POS)
) u_chk (
    .clk    (clk),
    .rst    (rst),
    .bit_en (bit_en),
    .tx_in  (tx_in),
    .tx_out (tx_out),
    .tx_vld (tx_vld),
    .oh_clk (oh_clk),
    .oh_sof (oh_sof),
    .inv_clk(inv_clk),
    .inv_sof(inv_sof),
    .bpos   (bpos),
    .blk    (blk),
    .stg_en (stg_en)
);

// File: tb/ds3oh_insert_test.sv
module ds3oh_insert_test;

    localparam int BB    = 85;
    localparam int NB    = 56;
    localparam int FL    = 42;
    localparam int FRAME = BB * NB;

    typedef struct {
        logic v;
        logic oh;
    } item_t;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst, bit_en, tx_in, tx_out, tx_vld, oh_clk, oh_sof, oh_data, oh_ena;
    logic inv_clk, inv_sof, inv_data, inv_ena;

    ds3oh_insert uut (
        .clk(clk), .rst(rst), .bit_en(bit_en), .tx_in(tx_in),
        .tx_out(tx_out), .tx_vld(tx_vld), .oh_clk(oh_clk), .oh_sof(oh_sof),
        .oh_data(oh_data), .oh_ena(oh_ena), .inv_clk(inv_clk), .inv_sof(inv_sof),
        .inv_data(inv_data), .inv_ena(inv_ena)
    );

    int    n_chk = 0;
    int    n_fail = 0;
    item_t exp_q[$];
    logic  ext_dat[NB];
    logic  ext_en[NB];
    int    nbits, ext_idx, cyc, run_cyc;
    logic  prev_oh, prev_en;
    logic [15:0] lfsr = 16'hACE1;
    bit    done = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Monitor: pops expected bits as the design produces them
    always @(negedge clk) begin
        if (!rst && tx_vld) begin
            if (exp_q.size() == 0) begin
                check(0, "R9 output without accepted bit", 1, 0);
            end else begin
                item_t e;
                e = exp_q.pop_front();
                if (e.oh) check(tx_out === e.v, "R4 overhead slot value", int'(tx_out), int'(e.v));
                else      check(tx_out === e.v, "R3 payload bit untouched", int'(tx_out), int'(e.v));
            end
        end
    end

    // External logic: acts on decoded port clock edges (R5, R6, R7, R8)
    task automatic ext_logic(input int mode);
        logic cur, s, v, e;
        int   k;
        cur = oh_clk ^ inv_clk;
        if (cur && !prev_oh) begin
            s = oh_sof ^ inv_sof;
            k = (nbits / BB) % NB;
            check(nbits % BB == 0, "R5 rise at block start", nbits % BB, 0);
            check(s == (k == NB - 1), "R6 start marker at rise", int'(s), int'(k == NB - 1));
            ext_idx = s ? 0 : (ext_idx + 1) % NB;
            case (mode)
                0: begin e = 1'b0; v = 1'b1; end
                1: begin e = 1'b1; v = ext_idx[0] ^ ((nbits / FRAME) % 2 == 1); end
                default: begin e = (ext_idx % 3 == 0); v = ~tx_in; end
            endcase
            ext_dat[ext_idx] = v;
            ext_en[ext_idx]  = e;
            oh_data = v ^ inv_data;
            oh_ena  = e ^ inv_ena;
        end else if (!cur && prev_oh) begin
            check(nbits % BB == FL + 1, "R5 fall after position 42", nbits % BB, FL + 1);
        end
        prev_oh = cur;
    endtask

    // Driver: one cycle, pushes the expected output bit
    task automatic tick(input bit en, input int mode);
        int p;
        @(negedge clk);
        ext_logic(mode);
        check(tx_vld == prev_en, "R9 valid follows strobe", int'(tx_vld), int'(prev_en));
        bit_en = en;
        prev_en = en;
        if (en) begin
            item_t it;
            tx_in = lfsr[0];
            lfsr = {lfsr[0] ^ lfsr[2] ^ lfsr[3] ^ lfsr[5], lfsr[15:1]};
            p = nbits % FRAME;
            it.oh = (p % BB == 0);
            it.v  = (it.oh && ext_en[p / BB]) ? ext_dat[p / BB] : tx_in;
            exp_q.push_back(it);
            nbits++;
        end
    endtask

    task automatic do_reset(input logic ic, input logic is, input logic id, input logic ie);
        @(negedge clk);
        rst = 1'b1; bit_en = 1'b0; tx_in = 1'b0;
        inv_clk = ic; inv_sof = is; inv_data = id; inv_ena = ie;
        oh_data = id; oh_ena = ie;
        repeat (3) @(negedge clk);
        // R1 reset state at the ports
        check((oh_clk ^ inv_clk) == 1'b1, "R1 port clock high in reset", int'(oh_clk ^ inv_clk), 1);
        check((oh_sof ^ inv_sof) == 1'b0, "R1 start marker low in reset", int'(oh_sof ^ inv_sof), 0);
        check(tx_vld == 1'b0, "R1 no valid in reset", int'(tx_vld), 0);
        exp_q.delete();
        for (int i = 0; i < NB; i++) begin
            ext_en[i] = 1'b0;
            ext_dat[i] = 1'b0;
        end
        nbits = 0; ext_idx = 1; prev_oh = 1'b1; prev_en = 1'b0;
        rst = 1'b0;
    endtask

    task automatic run(input int frames, input bit gaps, input int mode);
        run_cyc = 0;
        while (nbits < frames * FRAME + 2 * BB) begin
            tick(!(gaps && (run_cyc % 3 == 2)), mode);
            run_cyc++;
        end
        tick(1'b0, mode);
        tick(1'b0, mode);
        check(exp_q.size() == 0, "R2 every accepted bit emitted", exp_q.size(), 0);
    endtask

    initial begin
        rst = 1'b1; bit_en = 1'b0; tx_in = 1'b0; oh_data = 1'b0; oh_ena = 1'b0;
        inv_clk = 1'b0; inv_sof = 1'b0; inv_data = 1'b0; inv_ena = 1'b0;
        // R4 enable never set: framer bits kept
        do_reset(1'b0, 1'b0, 1'b0, 1'b0); run(1, 1'b0, 0);
        // R7 every slot overwritten with an index-dependent pattern
        do_reset(1'b0, 1'b0, 1'b0, 1'b0); run(2, 1'b0, 1);
        // R8 all signals inverted, sparse enables, R9 strobe gaps
        do_reset(1'b1, 1'b1, 1'b1, 1'b1); run(2, 1'b1, 2);
        // R8 mixed polarity
        do_reset(1'b1, 1'b0, 1'b1, 1'b0); run(1, 1'b1, 2);
        do_reset(1'b0, 1'b1, 1'b0, 1'b1); run(1, 1'b0, 1);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule